// File: doc/BRIEF.md
# PHY Discovery and Configuration Engine

After reset this block walks every management address on the serial management bus. It uses a simple request/acknowledge port into an MDIO master, which is a separate block. At each address it reads the status register and decides from its bit pattern whether a transceiver answers there. Each transceiver it finds is recorded in a small table. The block then makes sure that transceiver advertises the wanted abilities and brings its control register into a known state.

Configuration comes from four inputs:
- a forced-media selection, which switches autonegotiation off;
- a desired advertisement word, where zero means keep what the PHY offers;
- a force flag for full duplex;
- a force flag for 100 Mb/s.

When the walk ends, a done flag rises. The table and the count of found PHYs are then final. The control register is written a second time, after a settling gap counted in clock cycles, whenever its autonegotiation-enable bit changes.

Top module: `phy_scan_engine`

## Requirements
- R1: Status register 1 is read once per address, in the order 1, 2, …, 31 and then 0. A full walk with no PHY found is exactly 32 read requests.
- R2: A PHY is present when (status AND 0x8301) equals 0x8001. It is also present when status bit 15 is 0 and (status AND 0x7800) is nonzero. Any other status value means absent.
- R3: Found addresses fill the table in discovery order, with slot i in `phy_table[5i+4:5i]`. Unused slots read zero, and `phy_count` equals the number found.
- R4: For a present PHY, the status read is followed by a read of control register 0 and then a read of advertisement register 4. These reads come before any write to that PHY.
- R5: The target advertisement is chosen as follows:
  - `desired_adv`, if it is nonzero;
  - otherwise the value read from register 4, if any of its bits 8:5 (mask 0x01E0) is set;
  - otherwise ((status >> 6) AND 0x03E0) OR 1.

  Register 4 is written with the target only if the target differs from the value read.
- R6: The new control word is built from the value read from register 0, depending on `force_media`:
  - When `force_media` is 0, bit 12 is set. If that changes the word, bit 9 is also set and an autonegotiation switch is flagged.
  - When `force_media` is 1, bit 12 is cleared, and the switch is flagged if that changes the word.
- R7: Bits 15, 14, 13, 11, 10, 8 and 7 (mask 0xED80) of the new control word are then cleared. After that, bit 8 is set when `force_fdx` is 1 and bit 13 is set when `force_100` is 1.
- R8: If the new control word equals the value read, register 0 is not written. Otherwise it is written once. When the switch is flagged it is written twice, and the second request starts at least SETTLE_CYCLES cycles after the first is acknowledged.
- R9: Once MAX_PHYS PHYs have been found and configured, the walk stops and no further request is issued.
- R10: `scan_done` is 0 during reset and the walk. It rises after the last transaction and then stays high. From then on no request is issued, and the table and count do not change.
- R11: While `mdio_req` is high and `mdio_ack` is low, the request stays high and the operation, PHY address, register and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_media | input | 1 | 1 = forced media, autonegotiation disabled |
| desired_adv | input | 16 | Wanted advertisement word, 0 = use the PHY's own |
| force_fdx | input | 1 | Force full duplex in the control word |
| force_100 | input | 1 | Force 100 Mb/s in the control word |
| mdio_req | output | 1 | Management transaction request |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | Target PHY address |
| mdio_reg | output | 5 | Target register |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion pulse from the MDIO master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| phy_table | output | 5*MAX_PHYS | Found PHY addresses, slot 0 in the low bits |
| phy_count | output | clog2(MAX_PHYS+1) | Number of PHYs found |
| scan_done | output | 1 | Walk finished |

## Verification
The assertions rely on three assumptions about the inputs:
- the configuration inputs stay constant from reset release until `scan_done`;
- `mdio_ack` pulses for a single cycle, and only while `mdio_req` is high;
- `mdio_rdata` is meaningful only in that acknowledge cycle.

The bench keeps to these assumptions. It sets every configuration input before reset and leaves it alone. Its responder model acknowledges only a pending request, after a random latency of zero to three cycles, and drops the acknowledge on the following cycle.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

  localparam int unsigned PHY_AW  = 5;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned DATA_W  = 16;

  localparam logic [REG_AW-1:0] REG_CTRL = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 5'd1;
  localparam logic [REG_AW-1:0] REG_ADV  = 5'd4;

  localparam logic [DATA_W-1:0] CTRL_AN_EN    = 16'h1000;
  localparam logic [DATA_W-1:0] CTRL_AN_RST   = 16'h0200;
  localparam logic [DATA_W-1:0] CTRL_FDX      = 16'h0100;
  localparam logic [DATA_W-1:0] CTRL_SPD100   = 16'h2000;
  localparam logic [DATA_W-1:0] CTRL_CLR_MASK = 16'hED80;
  localparam logic [DATA_W-1:0] ADV_ABIL_MASK = 16'h01E0;

  typedef enum logic [3:0] {
    ST_RD_STAT, ST_RD_CTRL, ST_RD_ADV, ST_PLAN, ST_WR_ADV,
    ST_WR_CTRL_A, ST_SETTLE, ST_WR_CTRL_B, ST_ADVANCE, ST_DONE
  } scan_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] word;
    logic              sw;
  } ctrl_plan_t;

  function automatic logic phy_present(input logic [DATA_W-1:0] s);
    return ((s & 16'h8301) == 16'h8001) || (!s[15] && ((s & 16'h7800) != '0));
  endfunction

  function automatic logic [DATA_W-1:0] pick_adv(input logic [DATA_W-1:0] want,
                                                 input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] stat);
    logic [DATA_W-1:0] own;
    own = ((cur & ADV_ABIL_MASK) != '0) ? cur : (((stat >> 6) & 16'h03E0) | 16'h0001);
    return (want != '0) ? want : own;
  endfunction

  function automatic ctrl_plan_t plan_ctrl(input logic [DATA_W-1:0] cur,
                                           input logic forced,
                                           input logic fdx,
                                           input logic spd100);
    ctrl_plan_t p;
    p.word = forced ? (cur & ~CTRL_AN_EN) : (cur | CTRL_AN_EN);
    p.sw   = (p.word != cur);
    if (!forced && p.sw) p.word = p.word | CTRL_AN_RST;
    p.word = p.word & ~CTRL_CLR_MASK;
    if (fdx)    p.word = p.word | CTRL_FDX;
    if (spd100) p.word = p.word | CTRL_SPD100;
    return p;
  endfunction

endpackage

// File: rtl/scan_settle_timer.sv
module scan_settle_timer #(
  parameter int unsigned CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned LIM = (CYCLES < 1) ? 1 : CYCLES;
  localparam int unsigned CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CW'(LIM) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/scan_phy_table.sv
module scan_phy_table #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned AW    = 5,
  parameter int unsigned IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [AW-1:0]       wr_addr,
  output logic [SLOTS*AW-1:0] table_flat
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [AW-1:0] slot_q;
    logic          slot_en;
    assign slot_en = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wr_addr;
    end
    assign table_flat[i*AW +: AW] = slot_q;
  end
endmodule

// File: rtl/phy_scan_engine.sv
module phy_scan_engine
  import phy_scan_pkg::*;
#(
  parameter int unsigned MAX_PHYS      = 4,
  parameter int unsigned SETTLE_CYCLES = 500
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               force_media,
  input  logic [15:0]                        desired_adv,
  input  logic                               force_fdx,
  input  logic                               force_100,
  output logic                               mdio_req,
  output logic                               mdio_wr,
  output logic [4:0]                         mdio_phy,
  output logic [4:0]                         mdio_reg,
  output logic [15:0]                        mdio_wdata,
  input  logic                               mdio_ack,
  input  logic [15:0]                        mdio_rdata,
  output logic [MAX_PHYS*5-1:0]              phy_table,
  output logic [$clog2(MAX_PHYS+1)-1:0]      phy_count,
  output logic                               scan_done
);
  localparam int unsigned CNT_W = $clog2(MAX_PHYS + 1);
  localparam int unsigned IDX_W = (MAX_PHYS > 1) ? $clog2(MAX_PHYS) : 1;

  scan_state_t        state_q, state_d, after_adv;
  logic [PHY_AW-1:0]  addr_q, addr_d;
  logic [CNT_W-1:0]   count_q, count_d;
  logic [DATA_W-1:0]  stat_q, stat_d, ctrl_q, ctrl_d, adv_q, adv_d;
  logic               tbl_we, settle_start, settle_busy, regs_en;
  logic [DATA_W-1:0]  tgt_adv;
  ctrl_plan_t         plan;

  always_comb begin
    tgt_adv = pick_adv(desired_adv, adv_q, stat_q);
    plan    = plan_ctrl(ctrl_q, force_media, force_fdx, force_100);
    if (plan.word != ctrl_q) after_adv = plan.sw ? ST_WR_CTRL_A : ST_WR_CTRL_B;
    else                     after_adv = ST_ADVANCE;
  end

  always_comb begin
    state_d      = state_q;
    addr_d       = addr_q;
    count_d      = count_q;
    stat_d       = stat_q;
    ctrl_d       = ctrl_q;
    adv_d        = adv_q;
    tbl_we       = 1'b0;
    settle_start = 1'b0;
    unique case (state_q)
      ST_RD_STAT: if (mdio_ack) begin
        stat_d = mdio_rdata;
        if (phy_present(mdio_rdata)) begin
          tbl_we  = 1'b1;
          count_d = count_q + 1'b1;
          state_d = ST_RD_CTRL;
        end else begin
          state_d = ST_ADVANCE;
        end
      end
      ST_RD_CTRL: if (mdio_ack) begin
        ctrl_d  = mdio_rdata;
        state_d = ST_RD_ADV;
      end
      ST_RD_ADV: if (mdio_ack) begin
        adv_d   = mdio_rdata;
        state_d = ST_PLAN;
      end
      ST_PLAN:      state_d = (tgt_adv != adv_q) ? ST_WR_ADV : after_adv;
      ST_WR_ADV:    if (mdio_ack) state_d = after_adv;
      ST_WR_CTRL_A: if (mdio_ack) begin
        settle_start = 1'b1;
        state_d      = ST_SETTLE;
      end
      ST_SETTLE:    if (!settle_busy) state_d = ST_WR_CTRL_B;
      ST_WR_CTRL_B: if (mdio_ack) state_d = ST_ADVANCE;
      ST_ADVANCE: begin
        if ((count_q == CNT_W'(MAX_PHYS)) || (addr_q == '0)) begin
          state_d = ST_DONE;
        end else begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_RD_STAT;
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  assign regs_en = (state_q != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RD_STAT;
      addr_q  <= 5'd1;
      count_q <= '0;
      stat_q  <= '0;
      ctrl_q  <= '0;
      adv_q   <= '0;
    end else if (regs_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      count_q <= count_d;
      stat_q  <= stat_d;
      ctrl_q  <= ctrl_d;
      adv_q   <= adv_d;
    end
  end

  always_comb begin
    mdio_req   = 1'b1;
    mdio_wr    = 1'b0;
    mdio_reg   = REG_STAT;
    mdio_wdata = '0;
    case (state_q)
      ST_RD_STAT:   mdio_reg = REG_STAT;
      ST_RD_CTRL:   mdio_reg = REG_CTRL;
      ST_RD_ADV:    mdio_reg = REG_ADV;
      ST_WR_ADV: begin
        mdio_wr    = 1'b1;
        mdio_reg   = REG_ADV;
        mdio_wdata = tgt_adv;
      end
      ST_WR_CTRL_A, ST_WR_CTRL_B: begin
        mdio_wr    = 1'b1;
        mdio_reg   = REG_CTRL;
        mdio_wdata = plan.word;
      end
      default: mdio_req = 1'b0;
    endcase
  end

  assign mdio_phy  = addr_q;
  assign phy_count = count_q;
  assign scan_done = (state_q == ST_DONE);

  scan_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .busy  (settle_busy)
  );

  scan_phy_table #(.SLOTS(MAX_PHYS), .AW(PHY_AW), .IW(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (count_q[IDX_W-1:0]),
    .wr_addr    (addr_q),
    .table_flat (phy_table)
  );
endmodule

// File: rtl/phy_scan_checker.sv
module phy_scan_checker #(
  parameter int unsigned MAX_PHYS = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          mdio_req,
  input logic                          mdio_wr,
  input logic [4:0]                    mdio_phy,
  input logic [4:0]                    mdio_reg,
  input logic [15:0]                   mdio_wdata,
  input logic                          mdio_ack,
  input logic [MAX_PHYS*5-1:0]         phy_table,
  input logic [$clog2(MAX_PHYS+1)-1:0] phy_count,
  input logic                          scan_done
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_wr) && $stable(mdio_phy)
                                 && $stable(mdio_reg) && $stable(mdio_wdata)));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phy_count) <= MAX_PHYS);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> (scan_done && $stable(phy_count) && $stable(phy_table)));

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !mdio_req);

  assert_reg_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_reg == 5'd0 || mdio_reg == 5'd1 || mdio_reg == 5'd4));

  assert_status_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_wr) |-> (mdio_reg != 5'd1));
endmodule

bind phy_scan_engine phy_scan_checker #(.MAX_PHYS(MAX_PHYS)) u_chk (.*);

// File: tb/tb_phy_scan_engine.sv
module tb_phy_scan_engine;
  localparam int N      = 4;
  localparam int SETTLE = 40;
  localparam int LOGMAX = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        force_media = 1'b0, force_fdx = 1'b0, force_100 = 1'b0;
  logic [15:0] desired_adv = '0;
  logic        mdio_req, mdio_wr, mdio_ack = 1'b0, scan_done;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata = '0;
  logic [N*5-1:0] phy_table;
  logic [2:0]  phy_count;

  phy_scan_engine #(.MAX_PHYS(N), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .force_media(force_media), .desired_adv(desired_adv),
    .force_fdx(force_fdx), .force_100(force_100), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
    .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
    .mdio_rdata(mdio_rdata), .phy_table(phy_table), .phy_count(phy_count), .scan_done(scan_done));

  logic [15:0] m_stat [32];
  logic [15:0] m_ctrl [32];
  logic [15:0] m_adv  [32];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          lg_n = 0;
  logic        lg_wr   [LOGMAX];
  logic [4:0]  lg_phy  [LOGMAX];
  logic [4:0]  lg_reg  [LOGMAX];
  logic [15:0] lg_data [LOGMAX];
  int          lg_start[LOGMAX];
  int          lg_ack  [LOGMAX];

  int          ex_n = 0;
  logic        ex_wr   [LOGMAX];
  logic [4:0]  ex_phy  [LOGMAX];
  logic [4:0]  ex_reg  [LOGMAX];
  logic [15:0] ex_data [LOGMAX];

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Responder: acknowledges a pending request after 0..3 cycles
  initial begin
    bit in_txn = 0;
    int lat = 0;
    int st = 0;
    forever begin
      @(negedge clk);
      mdio_ack = 1'b0;
      if (!rst_n) begin
        in_txn = 0;
      end else if (mdio_req) begin
        if (!in_txn) begin
          in_txn = 1;
          st = cyc;
          lat = $urandom_range(0, 3);
        end
        if (lat == 0) begin
          if (lg_n < LOGMAX) begin
            lg_wr[lg_n] = mdio_wr; lg_phy[lg_n] = mdio_phy; lg_reg[lg_n] = mdio_reg;
            lg_data[lg_n] = mdio_wr ? mdio_wdata : 16'h0;
            lg_start[lg_n] = st; lg_ack[lg_n] = cyc;
            lg_n++;
          end
          case (mdio_reg)
            5'd0:    mdio_rdata = m_ctrl[mdio_phy];
            5'd1:    mdio_rdata = m_stat[mdio_phy];
            5'd4:    mdio_rdata = m_adv[mdio_phy];
            default: mdio_rdata = 16'hFFFF;
          endcase
          mdio_ack = 1'b1;
          in_txn = 0;
        end else begin
          lat--;
        end
      end
    end
  end

  function automatic bit b_present(input logic [15:0] s);
    if ((s & 16'h8301) == 16'h8001) return 1;
    return (s[15] == 1'b0) && ((s & 16'h7800) != 0);
  endfunction

  task automatic push(input logic wr, input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    ex_wr[ex_n] = wr; ex_phy[ex_n] = a; ex_reg[ex_n] = r; ex_data[ex_n] = d; ex_n++;
  endtask

  task automatic build_exp(output int cnt, output logic [N*5-1:0] tbl);
    cnt = 0; tbl = '0; ex_n = 0;
    for (int k = 0; k < 32; k++) begin
      logic [4:0] a;
      logic [15:0] t, c, nw;
      bit sw;
      a = (k == 31) ? 5'd0 : 5'(k + 1);
      push(0, a, 5'd1, 16'h0);
      if (b_present(m_stat[a])) begin
        tbl[cnt*5 +: 5] = a;
        cnt++;
        push(0, a, 5'd0, 16'h0);
        push(0, a, 5'd4, 16'h0);
        if (desired_adv != 0) t = desired_adv;
        else if ((m_adv[a] & 16'h01E0) != 0) t = m_adv[a];
        else t = ((m_stat[a] >> 6) & 16'h03E0) | 16'h1;
        if (t != m_adv[a]) push(1, a, 5'd4, t);
        c = m_ctrl[a];
        nw = force_media ? (c & 16'hEFFF) : (c | 16'h1000);
        sw = (nw != c);
        if (!force_media && sw) nw = nw | 16'h0200;
        nw = nw & 16'h127F;
        if (force_fdx) nw = nw | 16'h0100;
        if (force_100) nw = nw | 16'h2000;
        if (nw != c) begin
          if (sw) push(1, a, 5'd0, nw);
          push(1, a, 5'd0, nw);
        end
        if (cnt == N) break;
      end
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) begin
      m_stat[i] = 16'hFFFF; m_ctrl[i] = 16'h0; m_adv[i] = 16'h0;
    end
  endtask

  task automatic run(input string name);
    int ecnt, t;
    logic [N*5-1:0] etbl;
    @(negedge clk); rst_n = 1'b0; lg_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(scan_done == 1'b0 && phy_count == 0 && phy_table == '0, {name, " R10 reset state"},
        {scan_done, 8'(phy_count), 20'(phy_table)}, 0);
    t = 0;
    while (!scan_done && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, {name, " R10 watchdog"}, t, 20000);
    repeat (6) @(negedge clk);
    build_exp(ecnt, etbl);
    chk(lg_n == ex_n, {name, " R1 R9 transaction count"}, lg_n, ex_n);
    for (int i = 0; i < lg_n && i < ex_n; i++) begin
      bit ok;
      string tag;
      ok = (lg_wr[i] == ex_wr[i]) && (lg_phy[i] == ex_phy[i]) && (lg_reg[i] == ex_reg[i])
           && (lg_data[i] == ex_data[i]);
      if (ex_reg[i] == 5'd1)      tag = " R1 status read";
      else if (!ex_wr[i])         tag = " R4 register read";
      else if (ex_reg[i] == 5'd4) tag = " R5 advert write";
      else                        tag = " R6 R7 R8 control write";
      chk(ok, {name, tag}, {lg_wr[i], lg_phy[i], lg_reg[i], lg_data[i]},
          {ex_wr[i], ex_phy[i], ex_reg[i], ex_data[i]});
      if (i > 0 && ex_wr[i] && ex_reg[i] == 5'd0 && ex_wr[i-1] && ex_reg[i-1] == 5'd0
          && ex_phy[i] == ex_phy[i-1])
        chk(lg_start[i] - lg_ack[i-1] >= SETTLE, {name, " R8 settle gap"},
            lg_start[i] - lg_ack[i-1], SETTLE);
    end
    chk(int'(phy_count) == ecnt, {name, " R3 count"}, phy_count, ecnt);
    chk(phy_table == etbl, {name, " R2 R3 table"}, phy_table, etbl);
    chk(scan_done == 1'b1, {name, " R10 done held"}, scan_done, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));

    // nothing attached
    clear_model();
    m_stat[7] = 16'h0000;
    run("empty");

    // single PHY at address 0, derived advertisement, autoneg switch on
    clear_model();
    m_stat[0] = 16'h7809;
    m_stat[5] = 16'hF800;  // T4 bit set: absent (R2)
    m_stat[6] = 16'h8101;  // mask pattern off: absent (R2)
    run("addr0");

    // more PHYs than slots: early stop (R9), forced media with force flags
    clear_model();
    foreach (m_stat[i]) if (i inside {3, 5, 7, 9, 11, 0}) begin
      m_stat[i] = 16'h8001; m_ctrl[i] = 16'hFFFF; m_adv[i] = 16'h01E1;
    end
    force_media = 1'b1; force_fdx = 1'b1; force_100 = 1'b1; desired_adv = 16'h05E1;
    run("full");
    chk(lg_n > 0 && lg_phy[lg_n-1] == 5'd9, "full R9 last address", lg_phy[lg_n-1], 9);

    // already configured: no writes at all (R8, R5)
    clear_model();
    m_stat[31] = 16'h7849; m_ctrl[31] = 16'h1000; m_adv[31] = 16'h01E1;
    force_media = 1'b0; force_fdx = 1'b0; force_100 = 1'b0; desired_adv = 16'h0;
    run("clean");

    // random mixes
    for (int r = 0; r < 8; r++) begin
      clear_model();
      for (int i = 0; i < 32; i++) begin
        int kind;
        kind = $urandom_range(0, 5);
        case (kind)
          0: m_stat[i] = 16'hFFFF;
          1: m_stat[i] = 16'h0000;
          2: m_stat[i] = (16'($urandom) & 16'h7CFE) | 16'h8001;
          3: m_stat[i] = (16'($urandom) & 16'h7FFF) | 16'h0800;
          default: m_stat[i] = 16'($urandom);
        endcase
        m_ctrl[i] = 16'($urandom);
        m_adv[i]  = ($urandom_range(0, 1) == 1) ? 16'($urandom) : (16'($urandom) & 16'hFE1F);
      end
      force_media = 1'($urandom);
      force_fdx   = 1'($urandom);
      force_100   = 1'($urandom);
      desired_adv = ($urandom_range(0, 1) == 1) ? 16'($urandom) : 16'h0;
      run("random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule